// File: doc/BRIEF.md
# Guarded Configuration Store Controller

This block sits between a programmer-style command port and two small internal stores: a word-addressed configuration array and a 64-bit user signature. Commands arrive on a valid/ready handshake carrying a 3-bit opcode, an address and a data word. Every accepted command produces exactly one response pulse with a data word, a match flag and a refusal flag.

A lock bit protects the configuration array. It is set only by a dedicated command. While it is set, reading, writing and comparing array words are refused. The only way to clear it is a full erase, which also wipes the whole array and the signature. Two operations stay open at all times, whatever the lock: reading the signature, and forcing an arbitrary value into the state register. The state register supports test loading of state machines.

Writing a word performs its own erase first, so the stored word always equals the written data, whatever the word held before. A full erase is a multi-cycle operation. The command port is held not-ready until it completes.

Top module: `cfg_guard`

## Requirements
- R1: After reset, `state_o` is 0, `locked_o` is 0, `cmd_ready` is 1, `rsp_valid` is 0, every array word reads all ones, and signature chunk k equals `SIG_INIT[k*DATA_W +: DATA_W]`.
- R2: A command other than erase (opcode 0) that is accepted (`cmd_valid` and `cmd_ready` both high at a clock edge) gives one `rsp_valid` pulse after that same edge, and `cmd_ready` stays high. A new command can therefore be accepted every cycle.
- R3: Program (opcode 1) on an unlocked store sets the addressed word to exactly `cmd_data`, with no AND against its old contents. Read (opcode 2) then returns that word on `rsp_data`.
- R4: Verify (opcode 3) on an unlocked store returns the addressed word on `rsp_data`, and sets `rsp_match` to 1 exactly when the word equals `cmd_data`.
- R5: While `locked_o` is 1, program, read and verify are refused. The response has `rsp_denied`=1, `rsp_match`=0 and `rsp_data` all ones, and the array is left unchanged.
- R6: Lock (opcode 4) sets `locked_o` without refusal. Issuing it while already locked changes nothing and is not refused.
- R7: Erase (opcode 0) is accepted whether or not the lock is set. It holds `cmd_ready` low for `ERASE_CYCLES` cycles and gives its response `ERASE_CYCLES` edges after acceptance. In that same edge it sets every array word and all signature bits to ones and clears `locked_o`. Commands presented while `cmd_ready` is low are not accepted.
- R8: Signature read (opcode 5) returns chunk `cmd_addr` of the signature, with bits `[k*DATA_W +: DATA_W]` for chunk k, whether or not the store is locked. Chunk numbers at or above `SIG_BITS/DATA_W` are refused with all-ones data.
- R9: Preload (opcode 6) loads `cmd_data[STATE_W-1:0]` into `state_o` one edge after acceptance, locked or not, and is never refused.
- R10: Opcode 7 is refused with all-ones data and changes no state.
- R11: `rsp_denied` and `rsp_match` are only ever high while `rsp_valid` is high. On responses other than a successful read, verify or signature read, `rsp_data` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | Opcode: 0 erase, 1 program, 2 read, 3 verify, 4 lock, 5 signature read, 6 preload, 7 reserved |
| cmd_addr | input | ADDR_W | Array word address or signature chunk number |
| cmd_data | input | DATA_W | Write, compare or preload data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_denied | output | 1 | Command was refused |
| rsp_match | output | 1 | Verify comparison result |
| rsp_data | output | DATA_W | Returned word, all ones when no data applies |
| locked_o | output | 1 | Current lock state |
| state_o | output | STATE_W | Preloadable state register |

## Verification
The bench writes a word twice with complementary patterns. A program step that forgets its automatic erase would read back the AND of the two patterns instead of the second one. It also repeats the lock and then tries read, program and verify behind it. A leaky guard would return real array contents or alter the word that the post-erase readback later reveals. Signature reads and preloads are issued under lock, and a guard drawn too wide would refuse them. Erase is sent while locked, with commands held valid during the busy window. An off-by-one timer, a lock that survives erase, or a port that accepts during the erase all show up against the per-cycle reference model.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
    typedef enum logic [2:0] {
        OP_ERASE   = 3'd0,
        OP_PROG    = 3'd1,
        OP_READ    = 3'd2,
        OP_VERIFY  = 3'd3,
        OP_LOCK    = 3'd4,
        OP_SIG_RD  = 3'd5,
        OP_PRELOAD = 3'd6,
        OP_RSVD    = 3'd7
    } cmd_op_e;
endpackage

// File: rtl/cfg_guard_erase_timer.sv
module cfg_guard_erase_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        done_o = 1'b0;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.busy = 1'b0;
                done_o     = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CW'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy_o = tmr_q.busy;

    // R7: a new erase can only begin once the previous one has finished
    assert_start_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
    // R7: completion drops the busy flag at the next edge
    assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
endmodule

// File: rtl/cfg_guard_store.sv
module cfg_guard_store #(
    parameter int              ADDR_W   = 3,
    parameter int              DATA_W   = 16,
    parameter int              SIG_BITS = 64,
    parameter logic [SIG_BITS-1:0] SIG_INIT = '0
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          erase_i,
    input  logic                                          wr_en_i,
    input  logic [ADDR_W-1:0]                             addr_i,
    input  logic [DATA_W-1:0]                             wr_data_i,
    output logic [DATA_W-1:0]                             rd_word_o,
    input  logic [((SIG_BITS/DATA_W) > 1 ? $clog2(SIG_BITS/DATA_W) : 1)-1:0] sig_idx_i,
    output logic [DATA_W-1:0]                             sig_chunk_o
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] arr;
        logic [SIG_BITS-1:0]          sig;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (erase_i) begin
            st_d.arr = '1;
            st_d.sig = '1;
        end else if (wr_en_i) begin
            st_d.arr[addr_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.arr <= '1;
            st_q.sig <= SIG_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_word_o   = st_q.arr[addr_i];
    assign sig_chunk_o = st_q.sig[int'(sig_idx_i) * DATA_W +: DATA_W];

    // R3: a word write never disturbs the signature
    assert_write_keeps_sig_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !erase_i) |=> $stable(st_q.sig));
    // R5: with no write and no erase the array holds its contents
    assert_idle_keeps_array_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !erase_i) |=> $stable(st_q.arr));
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
    import cfg_guard_pkg::*;
#(
    parameter int                  ADDR_W       = 3,
    parameter int                  DATA_W       = 16,
    parameter int                  SIG_BITS     = 64,
    parameter logic [SIG_BITS-1:0] SIG_INIT     = 64'h0123_4567_89AB_CDEF,
    parameter int                  STATE_W      = 8,
    parameter int                  ERASE_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [2:0]         cmd_op,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [DATA_W-1:0]  cmd_data,
    output logic               rsp_valid,
    output logic               rsp_denied,
    output logic               rsp_match,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               locked_o,
    output logic [STATE_W-1:0] state_o
);
    localparam int SIG_CHUNKS = SIG_BITS / DATA_W;
    localparam int SIG_IW     = (SIG_CHUNKS > 1) ? $clog2(SIG_CHUNKS) : 1;

    typedef struct packed {
        logic               rsp_valid;
        logic               rsp_denied;
        logic               rsp_match;
        logic [DATA_W-1:0]  rsp_data;
        logic               locked;
        logic [STATE_W-1:0] state;
    } ctl_t;

    ctl_t        ctl_d, ctl_q;
    cmd_op_e     op;
    logic        accept;
    logic        tmr_start, tmr_busy, tmr_done;
    logic        store_wr;
    logic        sig_in_range;
    logic [DATA_W-1:0] rd_word, sig_chunk;

    assign op           = cmd_op_e'(cmd_op);
    assign cmd_ready    = !tmr_busy;
    assign accept       = cmd_valid && cmd_ready;
    assign sig_in_range = int'(cmd_addr) < SIG_CHUNKS;

    cfg_guard_erase_timer #(
        .CYCLES (ERASE_CYCLES)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .busy_o  (tmr_busy),
        .done_o  (tmr_done)
    );

    cfg_guard_store #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SIG_BITS (SIG_BITS),
        .SIG_INIT (SIG_INIT)
    ) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .erase_i     (tmr_done),
        .wr_en_i     (store_wr),
        .addr_i      (cmd_addr),
        .wr_data_i   (cmd_data),
        .rd_word_o   (rd_word),
        .sig_idx_i   (SIG_IW'(cmd_addr)),
        .sig_chunk_o (sig_chunk)
    );

    always_comb begin
        ctl_d            = ctl_q;
        ctl_d.rsp_valid  = 1'b0;
        ctl_d.rsp_denied = 1'b0;
        ctl_d.rsp_match  = 1'b0;
        ctl_d.rsp_data   = '1;
        tmr_start        = 1'b0;
        store_wr         = 1'b0;
        if (tmr_done) begin
            ctl_d.rsp_valid = 1'b1;
            ctl_d.locked    = 1'b0;
        end else if (accept) begin
            ctl_d.rsp_valid = 1'b1;
            case (op)
                OP_ERASE: begin
                    tmr_start       = 1'b1;
                    ctl_d.rsp_valid = 1'b0;
                end
                OP_PROG: begin
                    if (ctl_q.locked) ctl_d.rsp_denied = 1'b1;
                    else              store_wr         = 1'b1;
                end
                OP_READ: begin
                    if (ctl_q.locked) ctl_d.rsp_denied = 1'b1;
                    else              ctl_d.rsp_data   = rd_word;
                end
                OP_VERIFY: begin
                    if (ctl_q.locked) begin
                        ctl_d.rsp_denied = 1'b1;
                    end else begin
                        ctl_d.rsp_data  = rd_word;
                        ctl_d.rsp_match = (rd_word == cmd_data);
                    end
                end
                OP_LOCK: ctl_d.locked = 1'b1;
                OP_SIG_RD: begin
                    if (sig_in_range) ctl_d.rsp_data   = sig_chunk;
                    else              ctl_d.rsp_denied = 1'b1;
                end
                OP_PRELOAD: ctl_d.state = cmd_data[STATE_W-1:0];
                default: ctl_d.rsp_denied = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.rsp_data <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_valid  = ctl_q.rsp_valid;
    assign rsp_denied = ctl_q.rsp_denied;
    assign rsp_match  = ctl_q.rsp_match;
    assign rsp_data   = ctl_q.rsp_data;
    assign locked_o   = ctl_q.locked;
    assign state_o    = ctl_q.state;

    // R2: every accepted non-erase command answers at the next edge
    assert_rsp_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op != 3'd0) |=> rsp_valid);
    // R11: flags never appear without a response
    assert_flags_need_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_denied || rsp_match) |-> rsp_valid);
    // R5: guarded commands under lock are refused with all-ones data
    assert_locked_refusal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && locked_o && cmd_op inside {3'd1, 3'd2, 3'd3})
        |=> (rsp_denied && !rsp_match && rsp_data == '1));
    // R7: the lock only falls together with an erase response
    assert_unlock_by_erase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked_o) |-> (rsp_valid && !rsp_denied));
    // R6: lock command always leaves the store locked and is not refused
    assert_lock_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 3'd4) |=> (locked_o && !rsp_denied));
    // R9: preload is taken regardless of lock
    assert_preload_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 3'd6)
        |=> (!rsp_denied && state_o == $past(cmd_data[STATE_W-1:0])));
    // R8: in-range signature reads are never refused
    assert_sig_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 3'd5 && int'(cmd_addr) < SIG_CHUNKS)
        |=> !rsp_denied);
endmodule

// File: tb/test_cfg_guard.sv
`timescale 1ns/1ps
module test_cfg_guard;
    localparam logic [63:0] SIG_INIT = 64'hFACE_0B1E_5EED_C0DE;
    localparam int EC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [2:0]  cmd_addr = 3'd0;
    logic [15:0] cmd_data = 16'h0;
    logic        cmd_ready, rsp_valid, rsp_denied, rsp_match, locked_o;
    logic [15:0] rsp_data;
    logic [7:0]  state_o;

    int    vectors = 0;
    int    miscompares = 0;
    bit    finished = 1'b0;
    bit    model_live = 1'b0;
    string cur_tag = "R1";

    // reference model state
    logic [15:0] m_arr [8];
    logic [15:0] m_sig [4];
    logic        m_lock = 1'b0, m_busy = 1'b0;
    int          m_cnt = 0;
    logic [7:0]  m_state = 8'h0;
    logic        m_rv = 1'b0, m_rd = 1'b0, m_rm = 1'b0;
    logic [15:0] m_rdata = 16'hFFFF;

    always #2.5 clk = ~clk;

    cfg_guard #(
        .ADDR_W(3), .DATA_W(16), .SIG_BITS(64), .SIG_INIT(SIG_INIT),
        .STATE_W(8), .ERASE_CYCLES(EC)
    ) i_cfg_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_denied(rsp_denied), .rsp_match(rsp_match),
        .rsp_data(rsp_data), .locked_o(locked_o), .state_o(state_o)
    );

    always @(posedge clk) begin
        model_live = 1'b1;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_arr[i] = 16'hFFFF;
            for (int k = 0; k < 4; k++) m_sig[k] = SIG_INIT[k*16 +: 16];
            m_lock = 0; m_busy = 0; m_cnt = 0; m_state = 0;
            m_rv = 0; m_rd = 0; m_rm = 0; m_rdata = 16'hFFFF;
        end else begin
            m_rv = 0; m_rd = 0; m_rm = 0; m_rdata = 16'hFFFF;
            if (m_busy) begin
                if (m_cnt == 0) begin
                    m_busy = 0; m_lock = 0; m_rv = 1;
                    for (int i = 0; i < 8; i++) m_arr[i] = 16'hFFFF;
                    for (int k = 0; k < 4; k++) m_sig[k] = 16'hFFFF;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end else if (cmd_valid) begin
                m_rv = 1;
                case (cmd_op)
                    3'd0: begin m_rv = 0; m_busy = 1; m_cnt = EC - 1; end
                    3'd1: if (m_lock) m_rd = 1; else m_arr[cmd_addr] = cmd_data;
                    3'd2: if (m_lock) m_rd = 1; else m_rdata = m_arr[cmd_addr];
                    3'd3: if (m_lock) m_rd = 1;
                          else begin m_rdata = m_arr[cmd_addr]; m_rm = (m_arr[cmd_addr] == cmd_data); end
                    3'd4: m_lock = 1;
                    3'd5: if (cmd_addr < 4) m_rdata = m_sig[cmd_addr[1:0]]; else m_rd = 1;
                    3'd6: m_state = cmd_data[7:0];
                    default: m_rd = 1;
                endcase
            end
        end
    end

    task automatic cmp(input string fld, input string rq, input logic [15:0] got, input logic [15:0] exp);
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s (%s, %s): got %h expected %h at %0t", rq, cur_tag, fld, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_live && !finished) begin
            vectors++;
            cmp("cmd_ready",  "R7",  {15'd0, cmd_ready},  {15'd0, !m_busy});
            cmp("rsp_valid",  "R2",  {15'd0, rsp_valid},  {15'd0, m_rv});
            cmp("rsp_denied", "R5",  {15'd0, rsp_denied}, {15'd0, m_rd});
            cmp("rsp_match",  "R4",  {15'd0, rsp_match},  {15'd0, m_rm});
            cmp("rsp_data",   "R3",  rsp_data,            m_rdata);
            cmp("locked_o",   "R6",  {15'd0, locked_o},   {15'd0, m_lock});
            cmp("state_o",    "R9",  {8'd0, state_o},     {8'd0, m_state});
        end
    end

    task automatic issue(input logic [2:0] op, input logic [2:0] a, input logic [15:0] dat);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = dat;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        cur_tag = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(1);
        for (int k = 0; k < 4; k++) issue(3'd5, 3'(k), 16'h0);   // R1 initial signature
        issue(3'd2, 3'd6, 16'h0);                                 // R1 erased array
        idle(1);

        cur_tag = "R3";
        issue(3'd1, 3'd2, 16'h00FF);
        issue(3'd2, 3'd2, 16'h0);
        issue(3'd1, 3'd2, 16'hFF00);          // auto-erase: must read FF00, not 0000
        issue(3'd2, 3'd2, 16'h0);
        issue(3'd1, 3'd7, 16'h1234);
        issue(3'd1, 3'd0, 16'h0000);

        cur_tag = "R2";                        // back-to-back reads every cycle
        for (int a = 0; a < 8; a++) issue(3'd2, 3'(a), 16'h0);

        cur_tag = "R4";
        issue(3'd3, 3'd7, 16'h1234);
        issue(3'd3, 3'd7, 16'h1235);
        issue(3'd3, 3'd0, 16'h0000);

        cur_tag = "R8";
        issue(3'd5, 3'd3, 16'h0);
        issue(3'd5, 3'd5, 16'h0);              // out of range chunk

        cur_tag = "R10";
        issue(3'd7, 3'd2, 16'hDEAD);
        issue(3'd2, 3'd2, 16'h0);

        cur_tag = "R9";
        issue(3'd6, 3'd0, 16'hBEA5);

        cur_tag = "R6";
        issue(3'd4, 3'd0, 16'h0);
        issue(3'd4, 3'd0, 16'h0);              // repeated lock
        idle(1);

        cur_tag = "R5";
        issue(3'd2, 3'd2, 16'h0);
        issue(3'd1, 3'd2, 16'h0F0F);
        issue(3'd3, 3'd7, 16'h1234);

        cur_tag = "R8";
        issue(3'd5, 3'd1, 16'h0);              // signature open while locked
        cur_tag = "R9";
        issue(3'd6, 3'd0, 16'h003C);           // preload open while locked
        cur_tag = "R11";
        issue(3'd7, 3'd0, 16'h0);
        idle(2);

        cur_tag = "R7";
        issue(3'd0, 3'd0, 16'h0);              // erase while locked
        for (int i = 0; i < EC + 1; i++) issue(3'd2, 3'd2, 16'h0); // held valid during busy
        idle(2);
        issue(3'd2, 3'd2, 16'h0);
        issue(3'd2, 3'd7, 16'h0);
        for (int k = 0; k < 4; k++) issue(3'd5, 3'(k), 16'h0);
        issue(3'd1, 3'd4, 16'hA5A5);           // unlocked again after erase
        issue(3'd3, 3'd4, 16'hA5A5);
        idle(3);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule